// File: doc/BRIEF.md
# Paged Address Translator

This block maps a virtual address onto a physical address in a small paged memory. The virtual address is split into a page number and a 10-bit offset within a 1 KB page. The page number indexes a page table held in on-chip registers. The entry that is selected supplies a physical page number, which is joined to the unchanged offset. Several independent tables are kept, one per process, and a table-select input picks the one in force. The same virtual address can therefore land on different physical pages for different processes.

Each entry has three parts: a valid flag, a 2-bit permission code and a physical page number. A lookup carries an access kind (instruction fetch, data load or data store). Two outputs report a refused lookup, and they are kept apart. A missing mapping, or an address beyond the virtual page range, raises a page fault. A mapping that exists but does not permit the requested kind of access raises a protection violation. Translation is purely combinational. Software fills the tables through a single write port, and a write is seen by lookups from the next clock edge.

Top module: `pt_xlate`

## Requirements
- R1: On a granted lookup, pa[9:0] equals va[9:0].
- R2: On a granted lookup, pa[12:10] equals the physical page number stored in the entry at index va[14:10] of the table chosen by tbl_sel.
- R3: A lookup whose entry has its valid flag clear drives page_fault=1, prot_viol=0 and pa=0.
- R4: A lookup with va[15]=1 lies outside the 32-page range. It drives page_fault=1, prot_viol=0 and pa=0 whatever the table holds.
- R5: The permission codes are 00 read-only, 01 read/write, 10 execute-only and 11 read/write/execute. A store (acc=10) to a valid entry is granted only for codes 01 and 11. Otherwise prot_viol=1.
- R6: A fetch (acc=00) from a valid entry is granted only for codes 10 and 11. Otherwise prot_viol=1.
- R7: A load (acc=01) from a valid entry is granted for codes 00, 01 and 11, and refused with prot_viol=1 for code 10.
- R8: The access code 11 is reserved. On a valid entry it always gives prot_viol=1.
- R9: When prot_viol=1, page_fault=0 and pa=0.
- R10: A write with wr_tbl=t changes only table t. Lookups through any other table select return what they returned before the write.
- R11: A table write becomes visible to lookups after the clock edge that samples wr_en=1, and not before. Reset clears the valid flag of every entry in every table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes |
| rst_n | input | 1 | Active-low reset, clears all valid flags |
| tbl_sel | input | 1 | Table used for the lookup |
| va | input | 16 | Virtual address |
| acc | input | 2 | Access kind: 00 fetch, 01 load, 10 store, 11 reserved |
| pa | output | 13 | Physical address, zero when refused |
| page_fault | output | 1 | Missing mapping or out-of-range address |
| prot_viol | output | 1 | Mapping present but access kind not permitted |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | Table written |
| wr_vpn | input | 5 | Entry index written |
| wr_valid | input | 1 | Valid flag to store |
| wr_rights | input | 2 | Permission code to store |
| wr_ppn | input | 3 | Physical page number to store |

## Verification
The hardest case to reach is a write to an entry and a lookup of that same entry in the same cycle. Before the edge the old mapping must still show, and after it the new one. The bench drives both in one low clock phase and samples on each side of the rising edge. Random stimulus keeps the two tables differently populated and rewrites entries often. This way every permission code meets every access kind, on both tables, with valid and invalid entries mixed.

// File: rtl/pt_pkg.sv
package pt_pkg;

  // access kinds presented with a lookup
  localparam logic [1:0] ACC_FETCH = 2'b00;
  localparam logic [1:0] ACC_LOAD  = 2'b01;
  localparam logic [1:0] ACC_STORE = 2'b10;

  // permission codes: bit0 = writable, bit1 = executable
  localparam logic [1:0] PERM_RO  = 2'b00;
  localparam logic [1:0] PERM_RW  = 2'b01;
  localparam logic [1:0] PERM_XO  = 2'b10;
  localparam logic [1:0] PERM_RWX = 2'b11;

  function automatic logic perm_grants(input logic [1:0] perm, input logic [1:0] kind);
    logic ok;
    case (kind)
      ACC_FETCH: ok = perm[1];
      ACC_LOAD:  ok = (perm != PERM_XO);
      ACC_STORE: ok = perm[0];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic upper_clear(input logic [15:0] addr, input int unsigned low_bits);
    return (addr >> low_bits) == '0;
  endfunction

endpackage

// File: rtl/pt_split.sv
module pt_split #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 10,
  parameter int VPN_W = 5
) (
  input  logic [VA_W-1:0]  va,
  output logic [VPN_W-1:0] vpn,
  output logic [OFF_W-1:0] offset,
  output logic             in_range
);
  localparam int USED_W = OFF_W + VPN_W;

  assign offset = va[OFF_W-1:0];
  assign vpn    = va[USED_W-1:OFF_W];

  generate
    if (VA_W > USED_W) begin : g_upper
      logic [VA_W-USED_W-1:0] upper;
      assign upper    = va[VA_W-1:USED_W];
      assign in_range = (upper == '0);
    end else begin : g_exact
      assign in_range = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pt_table.sv
module pt_table #(
  parameter int VPN_W   = 5,
  parameter int PPN_W   = 3,
  parameter int TBL_CNT = 2,
  localparam int TSEL_W = (TBL_CNT > 1) ? $clog2(TBL_CNT) : 1,
  localparam int DEPTH  = 1 << VPN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TSEL_W-1:0] wr_tbl,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic              wr_valid,
  input  logic [1:0]        wr_rights,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [TSEL_W-1:0] rd_tbl,
  input  logic [VPN_W-1:0]  rd_vpn,
  output logic              rd_valid,
  output logic [1:0]        rd_rights,
  output logic [PPN_W-1:0]  rd_ppn
);
  logic             bank_valid  [TBL_CNT];
  logic [1:0]       bank_rights [TBL_CNT];
  logic [PPN_W-1:0] bank_ppn    [TBL_CNT];

  generate
    for (genvar t = 0; t < TBL_CNT; t++) begin : g_bank
      logic             valid_q  [DEPTH];
      logic [1:0]       rights_q [DEPTH];
      logic [PPN_W-1:0] ppn_q    [DEPTH];
      logic             hit_wr;

      assign hit_wr = wr_en && (wr_tbl == TSEL_W'(t));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int v = 0; v < DEPTH; v++) begin
            valid_q[v]  <= 1'b0;
            rights_q[v] <= '0;
            ppn_q[v]    <= '0;
          end
        end else if (hit_wr) begin
          valid_q[wr_vpn]  <= wr_valid;
          rights_q[wr_vpn] <= wr_rights;
          ppn_q[wr_vpn]    <= wr_ppn;
        end
      end

      assign bank_valid[t]  = valid_q[rd_vpn];
      assign bank_rights[t] = rights_q[rd_vpn];
      assign bank_ppn[t]    = ppn_q[rd_vpn];
    end
  endgenerate

  always_comb begin
    rd_valid  = 1'b0;
    rd_rights = '0;
    rd_ppn    = '0;
    for (int t = 0; t < TBL_CNT; t++) begin
      if (rd_tbl == TSEL_W'(t)) begin
        rd_valid  = bank_valid[t];
        rd_rights = bank_rights[t];
        rd_ppn    = bank_ppn[t];
      end
    end
  end
endmodule

// File: rtl/pt_check.sv
module pt_check (
  input  logic       in_range,
  input  logic       ent_valid,
  input  logic [1:0] ent_rights,
  input  logic [1:0] acc,
  output logic       fault,
  output logic       viol,
  output logic       grant
);
  import pt_pkg::*;

  assign fault = !in_range || !ent_valid;
  assign viol  = !fault && !perm_grants(ent_rights, acc);
  assign grant = !fault && !viol;
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 10,
  parameter int VPN_W   = 5,
  parameter int PPN_W   = 3,
  parameter int TBL_CNT = 2,
  localparam int TSEL_W = (TBL_CNT > 1) ? $clog2(TBL_CNT) : 1,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TSEL_W-1:0] tbl_sel,
  input  logic [VA_W-1:0]   va,
  input  logic [1:0]        acc,
  output logic [PA_W-1:0]   pa,
  output logic              page_fault,
  output logic              prot_viol,
  input  logic              wr_en,
  input  logic [TSEL_W-1:0] wr_tbl,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic              wr_valid,
  input  logic [1:0]        wr_rights,
  input  logic [PPN_W-1:0]  wr_ppn
);
  // named internal events, also watched by the bound checker
  logic [VPN_W-1:0] look_vpn;
  logic [OFF_W-1:0] look_off;
  logic             range_ok;
  logic             ent_valid;
  logic [1:0]       ent_rights;
  logic [PPN_W-1:0] ent_ppn;
  logic             grant;

  pt_split #(.VA_W(VA_W), .OFF_W(OFF_W), .VPN_W(VPN_W)) u_split (
    .va(va), .vpn(look_vpn), .offset(look_off), .in_range(range_ok)
  );

  pt_table #(.VPN_W(VPN_W), .PPN_W(PPN_W), .TBL_CNT(TBL_CNT)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_vpn(wr_vpn),
    .wr_valid(wr_valid), .wr_rights(wr_rights), .wr_ppn(wr_ppn),
    .rd_tbl(tbl_sel), .rd_vpn(look_vpn),
    .rd_valid(ent_valid), .rd_rights(ent_rights), .rd_ppn(ent_ppn)
  );

  pt_check u_check (
    .in_range(range_ok), .ent_valid(ent_valid), .ent_rights(ent_rights),
    .acc(acc), .fault(page_fault), .viol(prot_viol), .grant(grant)
  );

  assign pa = grant ? {ent_ppn, look_off} : '0;
endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int VA_W   = 16,
  parameter int OFF_W  = 10,
  parameter int VPN_W  = 5,
  parameter int PPN_W  = 3,
  parameter int TSEL_W = 1,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int USED_W = OFF_W + VPN_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TSEL_W-1:0] tbl_sel,
  input logic [VA_W-1:0]   va,
  input logic [1:0]        acc,
  input logic [PA_W-1:0]   pa,
  input logic              page_fault,
  input logic              prot_viol,
  input logic              wr_en,
  input logic [TSEL_W-1:0] wr_tbl,
  input logic [VPN_W-1:0]  wr_vpn,
  input logic              wr_valid,
  input logic [1:0]        ent_rights
);
  logic va_high;
  assign va_high = (va >> USED_W) != '0;

  p_fault_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    page_fault |-> (!prot_viol && pa == '0));

  p_out_of_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    va_high |-> page_fault);

  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_fault && !prot_viol) |-> (pa[OFF_W-1:0] == va[OFF_W-1:0]));

  p_store_perm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_fault && acc == 2'b10 && !ent_rights[0]) |-> prot_viol);

  p_fetch_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_fault && acc == 2'b00 && !ent_rights[1]) |-> prot_viol);

  p_reserved_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_fault && acc == 2'b11) |-> prot_viol);

  p_viol_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_viol |-> (pa == '0 && !page_fault));

  p_unmap_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(wr_valid) && $past(wr_tbl) == tbl_sel &&
     $past(wr_vpn) == va[USED_W-1:OFF_W]) |-> page_fault);
endmodule

bind pt_xlate pt_xlate_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .TSEL_W(TSEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tbl_sel(tbl_sel), .va(va), .acc(acc), .pa(pa),
  .page_fault(page_fault), .prot_viol(prot_viol), .wr_en(wr_en),
  .wr_tbl(wr_tbl), .wr_vpn(wr_vpn), .wr_valid(wr_valid), .ent_rights(ent_rights)
);

// File: tb/sim_pt_xlate.sv
module sim_pt_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_sel = 1'b0;
  logic [15:0] va = '0;
  logic [1:0]  acc = '0;
  logic [12:0] pa;
  logic        page_fault, prot_viol;
  logic        wr_en = 1'b0;
  logic        wr_tbl = 1'b0;
  logic [4:0]  wr_vpn = '0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_rights = '0;
  logic [2:0]  wr_ppn = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // bench model of both tables
  logic       m_valid  [2][32];
  logic [1:0] m_rights [2][32];
  logic [2:0] m_ppn    [2][32];

  pt_xlate u0 (
    .clk(clk), .rst_n(rst_n), .tbl_sel(tbl_sel), .va(va), .acc(acc), .pa(pa),
    .page_fault(page_fault), .prot_viol(prot_viol), .wr_en(wr_en),
    .wr_tbl(wr_tbl), .wr_vpn(wr_vpn), .wr_valid(wr_valid),
    .wr_rights(wr_rights), .wr_ppn(wr_ppn)
  );

  always #4 clk = ~clk;

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      report();
    end
  end

  // permission table written as explicit cases (R5 R6 R7 R8)
  function automatic bit allowed(input logic [1:0] r, input logic [1:0] k);
    case ({r, k})
      4'b00_01, 4'b01_01, 4'b11_01: return 1'b1; // loads
      4'b01_10, 4'b11_10:           return 1'b1; // stores
      4'b10_00, 4'b11_00:           return 1'b1; // fetches
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic [14:0] expect_out(input logic t, input logic [15:0] a, input logic [1:0] k);
    int idx = int'(a[14:10]);
    if (a[15] || !m_valid[t][idx]) return {1'b1, 1'b0, 13'd0};
    if (!allowed(m_rights[t][idx], k)) return {1'b0, 1'b1, 13'd0};
    return {1'b0, 1'b0, m_ppn[t][idx], a[9:0]};
  endfunction

  function automatic string tag_for(input logic t, input logic [15:0] a, input logic [1:0] k);
    int idx = int'(a[14:10]);
    if (a[15]) return "R4";
    if (!m_valid[t][idx]) return "R3";
    if (k == 2'b11) return "R8";
    if (!allowed(m_rights[t][idx], k))
      return (k == 2'b10) ? "R5 R9" : (k == 2'b00) ? "R6 R9" : "R7 R9";
    return "R1 R2";
  endfunction

  task automatic compare(input string tag, input logic [14:0] exp_v);
    logic [14:0] got = {page_fault, prot_viol, pa};
    checks++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s: actual fault=%b viol=%b pa=%h expected fault=%b viol=%b pa=%h",
               tag, got[14], got[13], got[12:0], exp_v[14], exp_v[13], exp_v[12:0]);
    end
  endtask

  task automatic probe(input logic t, input logic [15:0] a, input logic [1:0] k, input string tag);
    @(negedge clk);
    tbl_sel = t; va = a; acc = k;
    #1;
    compare(tag, expect_out(t, a, k));
  endtask

  task automatic write_ent(input logic t, input logic [4:0] v, input logic val,
                           input logic [1:0] r, input logic [2:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_tbl = t; wr_vpn = v; wr_valid = val; wr_rights = r; wr_ppn = p;
    @(posedge clk); #1;
    wr_en = 1'b0;
    m_valid[t][v] = val; m_rights[t][v] = r; m_ppn[t][v] = p;
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    for (int t = 0; t < 2; t++)
      for (int v = 0; v < 32; v++) begin
        m_valid[t][v] = 1'b0; m_rights[t][v] = '0; m_ppn[t][v] = '0;
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset: every entry invalid
    probe(1'b0, 16'h0000, 2'b01, "R11 reset");
    probe(1'b1, 16'h7FFF, 2'b00, "R11 reset");

    // R1 R2 directed mapping
    write_ent(1'b0, 5'd3, 1'b1, 2'b11, 3'd5);
    probe(1'b0, {1'b0, 5'd3, 10'h3FF}, 2'b01, "R1 R2");
    probe(1'b0, {1'b0, 5'd3, 10'h000}, 2'b00, "R1 R2");

    // R4 out of range with a valid entry behind it
    probe(1'b0, {1'b1, 5'd3, 10'h155}, 2'b01, "R4");

    // R5 R6 R7 R8 every permission code against every access kind
    for (int r = 0; r < 4; r++) begin
      write_ent(1'b1, 5'd9, 1'b1, 2'(r), 3'd2);
      for (int k = 0; k < 4; k++)
        probe(1'b1, {1'b0, 5'd9, 10'h0A5}, 2'(k), tag_for(1'b1, {1'b0, 5'd9, 10'h0A5}, 2'(k)));
    end

    // R10 same index, different tables
    write_ent(1'b0, 5'd17, 1'b1, 2'b01, 3'd3);
    write_ent(1'b1, 5'd17, 1'b1, 2'b00, 3'd6);
    probe(1'b0, {1'b0, 5'd17, 10'h011}, 2'b10, "R10");
    probe(1'b1, {1'b0, 5'd17, 10'h011}, 2'b01, "R10");
    write_ent(1'b1, 5'd17, 1'b0, 2'b11, 3'd7);
    probe(1'b0, {1'b0, 5'd17, 10'h011}, 2'b01, "R10 untouched");
    probe(1'b1, {1'b0, 5'd17, 10'h011}, 2'b01, "R10 R3");

    // R11 write and lookup of the same entry in one cycle
    @(negedge clk);
    tbl_sel = 1'b0; va = {1'b0, 5'd3, 10'h2C0}; acc = 2'b01;
    wr_en = 1'b1; wr_tbl = 1'b0; wr_vpn = 5'd3; wr_valid = 1'b1; wr_rights = 2'b00; wr_ppn = 3'd1;
    #1 compare("R11 before edge", expect_out(1'b0, va, acc));
    @(posedge clk); #1;
    wr_en = 1'b0;
    m_valid[0][3] = 1'b1; m_rights[0][3] = 2'b00; m_ppn[0][3] = 3'd1;
    compare("R11 after edge", expect_out(1'b0, va, acc));

    // random mix of writes and lookups
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0)
        write_ent(1'($urandom), 5'($urandom), ($urandom_range(0, 3) != 0),
                  2'($urandom), 3'($urandom));
      else begin
        logic        t = 1'($urandom);
        logic [15:0] a = 16'($urandom);
        logic [1:0]  k = 2'($urandom);
        if ($urandom_range(0, 7) != 0) a[15] = 1'b0;
        probe(t, a, k, tag_for(t, a, k));
      end
    end

    report();
  end
endmodule